// File: doc/BRIEF.md
# Elephant-Aware Segmented Set Replacement Controller

This block keeps the replacement order of one set of a flow cache and decides, cycle by cycle, where records enter, move and leave. The ways of the set are ranked by position and split into three segments: a low segment that absorbs short flows, a middle segment, and a protected high segment that shelters long-lived flows. Each way holds a record made of a valid flag, a flow identifier, a saved eviction count, a reference bit and a burst bit.

On a miss the caller presents the incoming identifier with the eviction count that was saved for that flow. The count is compared with two thresholds: `cfg_beta` for the low boundary and `cfg_alpha` for the high one. The result picks the segment the record goes into. On a hit the caller presents the position of the hit way, and the record is promoted. Records leave the low and middle segments only when new inserts push them out. Records leave the protected segment only through second-chance ageing, which runs once after every `AGE_PERIOD` push-outs. Every leaving record is reported on its way's eviction outputs with its count already updated, so it can be written back to the flow table. The per-way move selects tell the storage around the block where each way's next content comes from.

Positions are numbered 0 (lowest) to 7 (highest). With the default sizes, ways 0..2 form the low segment, 3..4 the middle segment and 5..7 the protected segment. The head of each segment is its highest-numbered way.

Top module: `segrep_ctrl`

## Requirements
- R1: A miss with count below `cfg_beta` places the new record (reference and burst bits clear) at way 2. Ways 0..1 take the content of the way above them. A valid record previously at way 0 leaves the set and is reported on way 0's eviction outputs.
- R2: A miss with count at least `cfg_beta` and below `cfg_alpha` does the same within the middle segment: the new record goes to way 4, way 3 takes way 4's content, and a valid record previously at way 3 leaves the set.
- R3: A miss with count at least `cfg_alpha` places the record, with its reference bit set, in the highest-numbered empty protected way if one exists. Otherwise it goes to way 7, ways 5..6 take the content above them, and a valid record previously at way 5 leaves the set.
- R4: A leaving record is reported on its way's `evt_*` outputs for exactly one cycle. The reported count is the stored count plus 1, or plus `cfg_step` when the record's burst bit is set. The sum saturates at 31.
- R5: A hit on a valid protected way sets that record's reference bit and moves it to way 7. The protected ways that were above it each move down one place.
- R6: A hit on valid way 4 sets the record's reference and burst bits. If a protected way is empty, the record moves to the highest-numbered empty protected way and way 4 becomes empty. Otherwise it swaps places with way 5.
- R7: A hit on any other valid low or middle way swaps that record with the way directly above it. A hit on an empty way changes nothing.
- R8: After every `AGE_PERIOD` (default 16) miss push-outs, `aging` is high for exactly the next cycle. In that cycle, each valid protected record with its reference bit set has the bit cleared, and each one with the bit clear leaves the set, leaving an empty way. `hole` is high whenever a protected way is empty.
- R9: An access presented while `aging` is high is ignored. When a miss and a hit arrive in the same cycle, the miss is served and the hit is ignored.
- R10: `way_sel` gives 3 bits per way describing the last update: 0 hold, 1 new record, 2 content from the way above, 3 content from the way below, 4 record brought from a non-adjacent way, 5 way emptied.
- R11: After reset, and across cycles with no access, all ways are empty, all outputs are zero except `hole`, and the state does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_beta | input | 5 | Low/middle count threshold |
| cfg_alpha | input | 5 | Middle/protected count threshold |
| cfg_step | input | 5 | Count increment for leaving burst records |
| miss_valid | input | 1 | Miss record present this cycle |
| miss_id | input | 8 | Identifier of the missing flow |
| miss_cnt | input | 5 | Saved eviction count of the missing flow |
| hit_valid | input | 1 | Hit present this cycle |
| hit_way | input | 3 | Position of the hit way |
| aging | output | 1 | Ageing sweep happens this cycle; accesses ignored |
| hole | output | 1 | A protected way is empty |
| way_valid | output | 8 | Valid flag per way |
| way_id | output | 64 | Identifier per way, 8 bits each |
| way_cnt | output | 40 | Stored eviction count per way, 5 bits each |
| way_ref | output | 8 | Reference bit per way |
| way_bst | output | 8 | Burst bit per way |
| way_sel | output | 24 | Move select per way, 3 bits each |
| evt_valid | output | 8 | Record left from this way last cycle |
| evt_id | output | 64 | Identifier of the leaving record per way |
| evt_cnt | output | 40 | Updated count of the leaving record per way |

## Verification
The hardest situation to reach is an ageing sweep that meets a protected segment holding a mix of referenced, unreferenced and empty ways, together with a burst-marked record whose count is close to saturation. Getting there needs many push-outs in the low and middle segments, hits that lift records across the middle head, and protected hits between sweeps. The stimulus mixes directed sequences with a long stream of random misses and hits. The random counts are spread over the full 5-bit range, and the thresholds and step are reloaded periodically, so that every segment keeps filling and draining. Because the ageing cycle then lands on arbitrary accesses, the ignore rule also gets exercised.

// File: rtl/segrep_pkg.sv
package segrep_pkg;

    localparam int SR_ID_W  = 8;
    localparam int SR_CNT_W = 5;

    typedef struct packed {
        logic                vld;
        logic                refb;
        logic                bst;
        logic [SR_CNT_W-1:0] cnt;
        logic [SR_ID_W-1:0]  id;
    } slot_t;

    typedef enum logic [2:0] {
        MV_HOLD  = 3'd0,
        MV_NEW   = 3'd1,
        MV_ABOVE = 3'd2,
        MV_BELOW = 3'd3,
        MV_JUMP  = 3'd4,
        MV_DROP  = 3'd5
    } mv_e;

    typedef enum logic [1:0] {
        SEG_LOW = 2'd0,
        SEG_MID = 2'd1,
        SEG_PRO = 2'd2
    } seg_e;

    function automatic logic [SR_CNT_W-1:0] sat_add(
        input logic [SR_CNT_W-1:0] a,
        input logic [SR_CNT_W-1:0] b
    );
        logic [SR_CNT_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        return s[SR_CNT_W] ? {SR_CNT_W{1'b1}} : s[SR_CNT_W-1:0];
    endfunction

endpackage

// File: rtl/segrep_classify.sv
module segrep_classify
    import segrep_pkg::*;
(
    input  logic [SR_CNT_W-1:0] cnt,
    input  logic [SR_CNT_W-1:0] beta,
    input  logic [SR_CNT_W-1:0] alpha,
    output seg_e                seg
);
    always_comb begin
        if (cnt < beta)       seg = SEG_LOW;
        else if (cnt < alpha) seg = SEG_MID;
        else                  seg = SEG_PRO;
    end
endmodule

// File: rtl/segrep_hole_find.sv
module segrep_hole_find #(
    parameter  int N     = 3,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     empty,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = 0; i < N; i++) begin
            if (empty[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/segrep_ager.sv
module segrep_ager #(
    parameter  int PERIOD = 16,
    localparam int CW     = $clog2(PERIOD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    output logic pending
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pending <= 1'b0;
        end else if (pending) begin
            pending <= 1'b0;
        end else if (push) begin
            if (cnt_q == CW'(PERIOD - 1)) begin
                cnt_q   <= '0;
                pending <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/segrep_cnt_upd.sv
module segrep_cnt_upd
    import segrep_pkg::*;
(
    input  logic [SR_CNT_W-1:0] cnt_in,
    input  logic                bst,
    input  logic [SR_CNT_W-1:0] step,
    output logic [SR_CNT_W-1:0] cnt_out
);
    assign cnt_out = sat_add(cnt_in, bst ? step : SR_CNT_W'(1));
endmodule

// File: rtl/segrep_ctrl.sv
module segrep_ctrl
    import segrep_pkg::*;
#(
    parameter  int N_LOW      = 3,
    parameter  int N_MID      = 2,
    parameter  int N_PROT     = 3,
    parameter  int AGE_PERIOD = 2 * (N_LOW + N_MID + N_PROT),
    localparam int WAYS       = N_LOW + N_MID + N_PROT,
    localparam int WAY_W      = $clog2(WAYS),
    localparam int IW         = SR_ID_W,
    localparam int CW         = SR_CNT_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     cfg_beta,
    input  logic [CW-1:0]     cfg_alpha,
    input  logic [CW-1:0]     cfg_step,
    input  logic              miss_valid,
    input  logic [IW-1:0]     miss_id,
    input  logic [CW-1:0]     miss_cnt,
    input  logic              hit_valid,
    input  logic [WAY_W-1:0]  hit_way,
    output logic              aging,
    output logic              hole,
    output logic [WAYS-1:0]   way_valid,
    output logic [WAYS*IW-1:0] way_id,
    output logic [WAYS*CW-1:0] way_cnt,
    output logic [WAYS-1:0]   way_ref,
    output logic [WAYS-1:0]   way_bst,
    output logic [WAYS*3-1:0] way_sel,
    output logic [WAYS-1:0]   evt_valid,
    output logic [WAYS*IW-1:0] evt_id,
    output logic [WAYS*CW-1:0] evt_cnt
);
    localparam int LOW_HI = N_LOW - 1;
    localparam int MID_LO = N_LOW;
    localparam int MID_HI = N_LOW + N_MID - 1;
    localparam int PRO_LO = N_LOW + N_MID;
    localparam int PRO_HI = WAYS - 1;
    localparam int HW     = (N_PROT > 1) ? $clog2(N_PROT) : 1;

    slot_t st_q [WAYS];
    mv_e   mv_q [WAYS];
    logic  evv_q [WAYS];
    logic [IW-1:0] evid_q [WAYS];
    logic [CW-1:0] evcnt_q [WAYS];

    slot_t nxt [WAYS];
    mv_e   mv  [WAYS];
    logic  lv_v [WAYS];
    logic  lv_bst [WAYS];
    logic [IW-1:0] lv_id [WAYS];
    logic [CW-1:0] lv_cnt [WAYS];
    logic [CW-1:0] upd_cnt [WAYS];

    seg_e  seg;
    logic  hole_found;
    logic [HW-1:0] hole_idx;
    logic [N_PROT-1:0] pro_empty;
    logic [WAY_W-1:0] hole_way;
    logic [WAY_W-1:0] up_way;
    logic  push;
    logic  do_rot;
    int    rot_lo, rot_hi;
    slot_t new_rec, hit_rec;

    segrep_classify u_cls (
        .cnt   (miss_cnt),
        .beta  (cfg_beta),
        .alpha (cfg_alpha),
        .seg   (seg)
    );

    for (genvar g = 0; g < N_PROT; g++) begin : g_empty
        assign pro_empty[g] = ~st_q[PRO_LO + g].vld;
    end

    segrep_hole_find #(.N(N_PROT)) u_hole (
        .empty (pro_empty),
        .found (hole_found),
        .idx   (hole_idx)
    );

    segrep_ager #(.PERIOD(AGE_PERIOD)) u_age (
        .clk     (clk),
        .rst     (rst),
        .push    (push),
        .pending (aging)
    );

    assign hole_way = WAY_W'(PRO_LO) + WAY_W'(hole_idx);
    assign up_way   = hit_way + 1'b1;
    assign hole     = hole_found;

    always_comb begin
        for (int i = 0; i < WAYS; i++) begin
            nxt[i]    = st_q[i];
            mv[i]     = MV_HOLD;
            lv_v[i]   = 1'b0;
            lv_bst[i] = 1'b0;
            lv_id[i]  = '0;
            lv_cnt[i] = '0;
        end
        push    = 1'b0;
        do_rot  = 1'b0;
        rot_lo  = 0;
        rot_hi  = LOW_HI;
        new_rec = '{vld: 1'b1, refb: 1'b0, bst: 1'b0, cnt: miss_cnt, id: miss_id};
        hit_rec = st_q[hit_way];
        hit_rec.refb = 1'b1;

        if (aging) begin
            // second-chance sweep of the protected segment
            for (int i = PRO_LO; i <= PRO_HI; i++) begin
                if (st_q[i].vld) begin
                    if (st_q[i].refb) begin
                        nxt[i].refb = 1'b0;
                    end else begin
                        lv_v[i]   = 1'b1;
                        lv_bst[i] = st_q[i].bst;
                        lv_id[i]  = st_q[i].id;
                        lv_cnt[i] = st_q[i].cnt;
                        nxt[i]    = '0;
                        mv[i]     = MV_DROP;
                    end
                end
            end
        end else if (miss_valid) begin
            case (seg)
                SEG_LOW: begin
                    do_rot = 1'b1;
                    rot_lo = 0;
                    rot_hi = LOW_HI;
                end
                SEG_MID: begin
                    do_rot = 1'b1;
                    rot_lo = MID_LO;
                    rot_hi = MID_HI;
                end
                default: begin
                    new_rec.refb = 1'b1;
                    if (hole_found) begin
                        nxt[hole_way] = new_rec;
                        mv[hole_way]  = MV_NEW;
                    end else begin
                        do_rot = 1'b1;
                        rot_lo = PRO_LO;
                        rot_hi = PRO_HI;
                    end
                end
            endcase
            if (do_rot) begin
                for (int i = 0; i < WAYS - 1; i++) begin
                    if (i >= rot_lo && i < rot_hi) begin
                        nxt[i] = st_q[i+1];
                        mv[i]  = MV_ABOVE;
                    end
                end
                nxt[rot_hi] = new_rec;
                mv[rot_hi]  = MV_NEW;
                if (st_q[rot_lo].vld) begin
                    lv_v[rot_lo]   = 1'b1;
                    lv_bst[rot_lo] = st_q[rot_lo].bst;
                    lv_id[rot_lo]  = st_q[rot_lo].id;
                    lv_cnt[rot_lo] = st_q[rot_lo].cnt;
                    push           = 1'b1;
                end
            end
        end else if (hit_valid && st_q[hit_way].vld) begin
            if (int'(hit_way) >= PRO_LO) begin
                for (int i = PRO_LO; i < PRO_HI; i++) begin
                    if (i >= int'(hit_way)) begin
                        nxt[i] = st_q[i+1];
                        mv[i]  = MV_ABOVE;
                    end
                end
                nxt[PRO_HI] = hit_rec;
                mv[PRO_HI]  = (int'(hit_way) == PRO_HI) ? MV_HOLD : MV_JUMP;
            end else if (int'(hit_way) == MID_HI) begin
                hit_rec.bst = 1'b1;
                if (hole_found) begin
                    nxt[hole_way] = hit_rec;
                    mv[hole_way]  = MV_JUMP;
                    nxt[MID_HI]   = '0;
                    mv[MID_HI]    = MV_DROP;
                end else begin
                    nxt[PRO_LO] = hit_rec;
                    mv[PRO_LO]  = MV_BELOW;
                    nxt[MID_HI] = st_q[PRO_LO];
                    mv[MID_HI]  = MV_ABOVE;
                end
            end else begin
                nxt[up_way]  = st_q[hit_way];
                mv[up_way]   = MV_BELOW;
                nxt[hit_way] = st_q[up_way];
                mv[hit_way]  = MV_ABOVE;
            end
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        segrep_cnt_upd u_upd (
            .cnt_in  (lv_cnt[g]),
            .bst     (lv_bst[g]),
            .step    (cfg_step),
            .cnt_out (upd_cnt[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[g]    <= '0;
                mv_q[g]    <= MV_HOLD;
                evv_q[g]   <= 1'b0;
                evid_q[g]  <= '0;
                evcnt_q[g] <= '0;
            end else begin
                st_q[g]    <= nxt[g];
                mv_q[g]    <= mv[g];
                evv_q[g]   <= lv_v[g];
                evid_q[g]  <= lv_v[g] ? lv_id[g] : '0;
                evcnt_q[g] <= lv_v[g] ? upd_cnt[g] : '0;
            end
        end

        assign way_valid[g]          = st_q[g].vld;
        assign way_id[g*IW +: IW]    = st_q[g].id;
        assign way_cnt[g*CW +: CW]   = st_q[g].cnt;
        assign way_ref[g]            = st_q[g].refb;
        assign way_bst[g]            = st_q[g].bst;
        assign way_sel[g*3 +: 3]     = mv_q[g];
        assign evt_valid[g]          = evv_q[g];
        assign evt_id[g*IW +: IW]    = evid_q[g];
        assign evt_cnt[g*CW +: CW]   = evcnt_q[g];
    end

endmodule

// File: rtl/segrep_chk.sv
module segrep_chk
    import segrep_pkg::*;
#(
    parameter  int N_LOW  = 3,
    parameter  int N_MID  = 2,
    parameter  int N_PROT = 3,
    localparam int WAYS   = N_LOW + N_MID + N_PROT,
    localparam int WAY_W  = $clog2(WAYS),
    localparam int IW     = SR_ID_W,
    localparam int CW     = SR_CNT_W
) (
    input logic               clk,
    input logic               rst,
    input logic [CW-1:0]      cfg_beta,
    input logic               miss_valid,
    input logic [IW-1:0]      miss_id,
    input logic [CW-1:0]      miss_cnt,
    input logic               hit_valid,
    input logic [WAY_W-1:0]   hit_way,
    input logic               aging,
    input logic [WAYS-1:0]    way_valid,
    input logic [WAYS*IW-1:0] way_id,
    input logic [WAYS-1:0]    way_ref,
    input logic [WAYS-1:0]    evt_valid,
    input logic [WAYS*CW-1:0] evt_cnt
);
    localparam int LOW_HI = N_LOW - 1;
    localparam int MID_HI = N_LOW + N_MID - 1;
    localparam int PRO_LO = N_LOW + N_MID;
    localparam int PRO_HI = WAYS - 1;

    AST_LOW_INSERT: assert property (@(posedge clk) disable iff (rst)
        (miss_valid && !aging && miss_cnt < cfg_beta) |=>
            (way_valid[LOW_HI] && way_id[LOW_HI*IW +: IW] == $past(miss_id))); // R1

    AST_ONE_PUSH: assert property (@(posedge clk) disable iff (rst)
        $onehot0(evt_valid[MID_HI:0])); // R1

    for (genvar g = 0; g < WAYS; g++) begin : g_evt
        AST_EVT_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
            evt_valid[g] |-> (evt_cnt[g*CW +: CW] != '0)); // R4
    end

    AST_PROT_HIT_HEAD: assert property (@(posedge clk) disable iff (rst)
        (hit_valid && !miss_valid && !aging && int'(hit_way) >= PRO_LO && way_valid[hit_way]) |=>
            (way_ref[PRO_HI] && way_id[PRO_HI*IW +: IW] == $past(way_id[hit_way*IW +: IW]))); // R5

    AST_AGING_CLEARS_REF: assert property (@(posedge clk) disable iff (rst)
        aging |=> ((way_valid[PRO_HI:PRO_LO] & way_ref[PRO_HI:PRO_LO]) == '0)); // R8

    AST_AGING_SINGLE: assert property (@(posedge clk) disable iff (rst)
        aging |=> !aging); // R8

    AST_AGING_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
        aging |=> ($stable(way_valid[MID_HI:0]) && $stable(way_id[(MID_HI+1)*IW-1:0]))); // R9

endmodule

bind segrep_ctrl segrep_chk #(
    .N_LOW  (N_LOW),
    .N_MID  (N_MID),
    .N_PROT (N_PROT)
) u_segrep_chk (
    .clk        (clk),
    .rst        (rst),
    .cfg_beta   (cfg_beta),
    .miss_valid (miss_valid),
    .miss_id    (miss_id),
    .miss_cnt   (miss_cnt),
    .hit_valid  (hit_valid),
    .hit_way    (hit_way),
    .aging      (aging),
    .way_valid  (way_valid),
    .way_id     (way_id),
    .way_ref    (way_ref),
    .evt_valid  (evt_valid),
    .evt_cnt    (evt_cnt)
);

// File: tb/tb_segrep_ctrl.sv
`timescale 1ns/1ps
module tb_segrep_ctrl;
    import segrep_pkg::*;

    localparam int W = 8, IW = SR_ID_W, CW = SR_CNT_W, PER = 16;
    localparam int LH = 2, ML = 3, MH = 4, PL = 5, PH = 7;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst = 1'b1;
    logic [CW-1:0] cfg_beta = 5'd2, cfg_alpha = 5'd6, cfg_step = 5'd4;
    logic miss_valid = 1'b0, hit_valid = 1'b0;
    logic [IW-1:0] miss_id = '0;
    logic [CW-1:0] miss_cnt = '0;
    logic [2:0] hit_way = '0;
    logic aging, hole;
    logic [W-1:0] way_valid, way_ref, way_bst, evt_valid;
    logic [W*IW-1:0] way_id, evt_id;
    logic [W*CW-1:0] way_cnt, evt_cnt;
    logic [W*3-1:0] way_sel;

    segrep_ctrl dut (
        .clk(clk), .rst(rst), .cfg_beta(cfg_beta), .cfg_alpha(cfg_alpha), .cfg_step(cfg_step),
        .miss_valid(miss_valid), .miss_id(miss_id), .miss_cnt(miss_cnt),
        .hit_valid(hit_valid), .hit_way(hit_way), .aging(aging), .hole(hole),
        .way_valid(way_valid), .way_id(way_id), .way_cnt(way_cnt), .way_ref(way_ref),
        .way_bst(way_bst), .way_sel(way_sel), .evt_valid(evt_valid), .evt_id(evt_id),
        .evt_cnt(evt_cnt)
    );

    int checks = 0, failures = 0;

    // reference model state
    logic m_v[W], m_r[W], m_b[W];
    logic [IW-1:0] m_id[W];
    logic [CW-1:0] m_c[W];
    logic o_v[W], o_r[W], o_b[W];
    logic [IW-1:0] o_id[W];
    logic [CW-1:0] o_c[W];
    int   e_sel[W];
    logic e_ev[W];
    logic [IW-1:0] e_eid[W];
    logic [CW-1:0] e_ecnt[W];
    logic m_pend;
    int   m_push;
    string tag;

    task automatic check(input bit ok, input string rq, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] satc(input logic [CW-1:0] c, input logic [CW-1:0] a);
        int s;
        s = int'(c) + int'(a);
        return (s > 31) ? 5'd31 : CW'(s);
    endfunction

    task automatic m_reset();
        for (int i = 0; i < W; i++) begin
            m_v[i] = 0; m_r[i] = 0; m_b[i] = 0; m_id[i] = '0; m_c[i] = '0;
            e_sel[i] = 0; e_ev[i] = 0; e_eid[i] = '0; e_ecnt[i] = '0;
        end
        m_pend = 0; m_push = 0;
    endtask

    task automatic put(input int d, input int s, input int code);
        m_v[d] = o_v[s]; m_r[d] = o_r[s]; m_b[d] = o_b[s]; m_id[d] = o_id[s]; m_c[d] = o_c[s];
        e_sel[d] = code;
    endtask

    task automatic clr(input int d);
        m_v[d] = 0; m_r[d] = 0; m_b[d] = 0; m_id[d] = '0; m_c[d] = '0; e_sel[d] = 5;
    endtask

    task automatic leave(input int s);
        e_ev[s] = 1; e_eid[s] = o_id[s];
        e_ecnt[s] = satc(o_c[s], o_b[s] ? cfg_step : 5'd1);
    endtask

    function automatic int top_hole();
        int h = -1;
        for (int i = PL; i <= PH; i++) if (!m_v[i]) h = i;
        return h;
    endfunction

    task automatic rot_insert(input int lo, input int hi, input logic [IW-1:0] id,
                              input logic [CW-1:0] c, input logic rf);
        if (o_v[lo]) begin leave(lo); m_push++; end
        for (int i = lo; i < hi; i++) put(i, i + 1, 2);
        m_v[hi] = 1; m_r[hi] = rf; m_b[hi] = 0; m_id[hi] = id; m_c[hi] = c; e_sel[hi] = 1;
    endtask

    task automatic model_step(input logic mv, input logic [IW-1:0] mid, input logic [CW-1:0] mc,
                              input logic hv, input logic [2:0] hw);
        int h;
        int w;
        w = int'(hw);
        for (int i = 0; i < W; i++) begin
            o_v[i] = m_v[i]; o_r[i] = m_r[i]; o_b[i] = m_b[i]; o_id[i] = m_id[i]; o_c[i] = m_c[i];
            e_sel[i] = 0; e_ev[i] = 0; e_eid[i] = '0; e_ecnt[i] = '0;
        end
        tag = "R11";
        if (m_pend) begin
            tag = (mv || hv) ? "R9" : "R8";
            for (int i = PL; i <= PH; i++) begin
                if (o_v[i]) begin
                    if (o_r[i]) m_r[i] = 0;
                    else begin leave(i); clr(i); end
                end
            end
            m_pend = 0;
        end else if (mv) begin
            if (mc < cfg_beta) begin
                tag = "R1"; rot_insert(0, LH, mid, mc, 0);
            end else if (mc < cfg_alpha) begin
                tag = "R2"; rot_insert(ML, MH, mid, mc, 0);
            end else begin
                tag = "R3";
                h = top_hole();
                if (h >= 0) begin
                    m_v[h] = 1; m_r[h] = 1; m_b[h] = 0; m_id[h] = mid; m_c[h] = mc; e_sel[h] = 1;
                end else rot_insert(PL, PH, mid, mc, 1);
            end
            if (hv) tag = {tag, "/R9"};
            if (m_push == PER) begin m_pend = 1; m_push = 0; end
        end else if (hv && o_v[w]) begin
            if (w >= PL) begin
                tag = "R5";
                for (int i = w; i < PH; i++) put(i, i + 1, 2);
                put(PH, w, (w == PH) ? 0 : 4);
                m_r[PH] = 1;
            end else if (w == MH) begin
                tag = "R6";
                h = top_hole();
                if (h >= 0) begin
                    put(h, MH, 4); clr(MH);
                end else begin
                    put(PL, MH, 3); put(MH, PL, 2);
                end
                m_r[(h >= 0) ? h : PL] = 1; m_b[(h >= 0) ? h : PL] = 1;
            end else begin
                tag = "R7";
                put(w + 1, w, 3); put(w, w + 1, 2);
            end
        end else if (hv) begin
            tag = "R7";
        end
    endtask

    task automatic compare();
        logic [63:0] ev, eid, ecnt, er, eb, esel, eev, eeid, eecnt;
        logic eh;
        ev = '0; eid = '0; ecnt = '0; er = '0; eb = '0; esel = '0; eev = '0; eeid = '0; eecnt = '0;
        eh = 0;
        for (int i = 0; i < W; i++) begin
            ev[i] = m_v[i]; er[i] = m_r[i]; eb[i] = m_b[i];
            eid[i*IW +: IW] = m_id[i]; ecnt[i*CW +: CW] = m_c[i];
            esel[i*3 +: 3] = 3'(e_sel[i]);
            eev[i] = e_ev[i]; eeid[i*IW +: IW] = e_eid[i]; eecnt[i*CW +: CW] = e_ecnt[i];
            if (i >= PL && !m_v[i]) eh = 1;
        end
        check(way_valid == ev[W-1:0], tag, "way_valid", 64'(way_valid), ev);
        check(way_id == eid, tag, "way_id", way_id, eid);
        check(way_cnt == ecnt[W*CW-1:0], tag, "way_cnt", 64'(way_cnt), ecnt);
        check(way_ref == er[W-1:0], tag, "way_ref", 64'(way_ref), er);
        check(way_bst == eb[W-1:0], tag, "way_bst", 64'(way_bst), eb);
        check(way_sel == esel[W*3-1:0], "R10", "way_sel", 64'(way_sel), esel);
        check(evt_valid == eev[W-1:0], "R4", "evt_valid", 64'(evt_valid), eev);
        check(evt_id == eeid, "R4", "evt_id", evt_id, eeid);
        check(evt_cnt == eecnt[W*CW-1:0], "R4", "evt_cnt", 64'(evt_cnt), eecnt);
        check(hole == eh, "R8", "hole", 64'(hole), 64'(eh));
        check(aging == m_pend, "R8", "aging", 64'(aging), 64'(m_pend));
    endtask

    task automatic op(input logic mv, input logic [IW-1:0] mid, input logic [CW-1:0] mc,
                      input logic hv, input logic [2:0] hw);
        miss_valid = mv; miss_id = mid; miss_cnt = mc; hit_valid = hv; hit_way = hw;
        @(posedge clk);
        model_step(mv, mid, mc, hv, hw);
        @(negedge clk);
        miss_valid = 0; hit_valid = 0;
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        m_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        tag = "R11";
        compare();                             // R11 reset state
        op(0, 0, 0, 1, 3'd0);                  // R7 hit on empty way ignored
        op(0, 0, 0, 0, 3'd0);                  // R11 idle holds
        op(1, 8'h11, 5'd0, 0, 0);              // R1
        op(1, 8'h12, 5'd1, 0, 0);
        op(1, 8'h13, 5'd0, 0, 0);
        op(1, 8'h14, 5'd30, 0, 0);             // R3 fills top hole
        cfg_beta = 5'd31;
        op(1, 8'h15, 5'd30, 0, 0);             // R1 push-out of 0x11, R4 count 1
        cfg_beta = 5'd2;
        op(1, 8'h21, 5'd3, 0, 0);              // R2
        op(1, 8'h22, 5'd5, 0, 0);
        op(1, 8'h31, 5'd9, 0, 0);              // R3 hole
        op(1, 8'h32, 5'd20, 0, 0);             // R3 last hole
        op(1, 8'h33, 5'd31, 0, 0);             // R3 rotation, push-out
        op(0, 0, 0, 1, 3'd5);                  // R5
        op(0, 0, 0, 1, 3'd7);                  // R5 head hit
        op(0, 0, 0, 1, 3'd4);                  // R6 swap
        op(0, 0, 0, 1, 3'd1);                  // R7
        op(1, 8'h41, 5'd0, 1, 3'd6);           // R9 miss beats hit
        for (int k = 0; k < 6000; k++) begin
            int r;
            logic [CW-1:0] c;
            if (k % 500 == 0) begin
                cfg_beta  = 5'($urandom % 8);
                cfg_alpha = cfg_beta + 5'($urandom % 14);
                cfg_step  = 5'(1 + $urandom % 10);
            end
            r = int'($urandom % 100);
            c = ($urandom % 2 == 0) ? 5'($urandom % 32) : 5'($urandom % 8);
            if (r < 40)      op(1, 8'($urandom), c, 0, 0);
            else if (r < 80) op(0, 0, 0, 1, 3'($urandom % 8));
            else if (r < 88) op(1, 8'($urandom), c, 1, 3'($urandom % 8));
            else             op(0, 0, 0, 0, 0);
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule